// File: doc/BRIEF.md
# Write-Back Data Cache with Victim Queue

This block is a tiny fully associative data cache placed between a processor port and a slow block memory. It holds two lines. Each line is a two-word block, with one word per byte address. A 5-bit byte address splits into a 4-bit tag (bits 4:1) and a 1-bit word select (bit 0). Stores are kept in the cache. A line marked modified is written to memory only when it is displaced. A miss always allocates a line, whether it is a load or a store.

A displaced modified line does not go straight to memory. It is appended to a short first-in first-out victim queue, and the queue drains to memory in the background. The refill read for the missing block can therefore start at once. Refill reads take precedence over queue drains. A refill whose block still sits in the queue takes the newest queued copy instead of reading memory. Counters report hits, misses and modified evictions.

The control state machine has four states:

- IDLE waits for a request. A hit goes to RESP. A miss latches the victim line and goes to EVICT.
- EVICT displaces the victim:
  - A clean or empty victim is dropped, and the machine goes to FILL.
  - A modified victim is queued when the queue has room, and the machine goes to FILL.
  - Otherwise the machine stays in EVICT.
- FILL installs the block, either from the queue or from a memory read. It then goes to RESP.
- RESP raises ready for one cycle and returns to IDLE.

Top module: `cwb_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready`, `mem_rd_req` and `mem_wr_req` are low, and all three counters read zero.
- R2: A load miss issues one block read for the request tag (`mem_rd_req` held until `mem_rd_ack`). The returned block has word 0 in bits 7:0 and word 1 in bits 15:8. It installs as a clean line, the requested word is returned, and `miss_count` increments.
- R3: A hit raises `cpu_ready` in the cycle after the request is accepted, for exactly one cycle. It makes no memory read, and `hit_count` increments.
- R4: A store hit, or a store that allocates, changes only the cached word and marks the line modified. No memory write is requested because of it.
- R5: Displacing a clean line produces no memory write.
- R6: Displacing a modified line queues the whole block under its own tag, and it is later written to memory as a block. `dirty_evict_count` increments.
- R7: On a miss, the first invalid line is chosen as victim. If none is invalid, the least recently used line is chosen, where every hit and every fill counts as a use.
- R8: Queued victims reach memory in the order they were displaced.
- R9: A miss whose victim is modified waits in EVICT while the queue is full, and completes only after a drain frees an entry.
- R10: A refill whose tag matches a queued victim takes the newest such queued block and issues no memory read.
- R11: `mem_wr_req` is never high while `mem_rd_req` is high. The queue drains only when no refill is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Request present; held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 5 | Byte address: tag in 4:1, word select in 0 |
| cpu_wdata | input | 8 | Store data |
| cpu_rdata | output | 8 | Word value after the access, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_rd_req | output | 1 | Block read request |
| mem_rd_tag | output | 4 | Block address of the read |
| mem_rd_ack | input | 1 | Read completes in a cycle where both request and acknowledge are high |
| mem_rd_data | input | 16 | Returned block, word 0 in 7:0 |
| mem_wr_req | output | 1 | Block write request from the victim queue head |
| mem_wr_tag | output | 4 | Block address of the write |
| mem_wr_data | output | 16 | Block data, word 0 in 7:0 |
| mem_wr_ack | input | 1 | Write completes in a cycle where both request and acknowledge are high |
| hit_count | output | 16 | Number of hits |
| miss_count | output | 16 | Number of misses |
| dirty_evict_count | output | 16 | Number of modified lines queued |

## Verification
Two events can fall in the same cycle: a refill read and a pending queue drain. The bench provokes this by holding memory write acknowledges back while forcing further modified evictions. Refills then run with the queue non-empty, and a monitor counts any cycle where both memory requests are high. The same held queue is used to check that a refill of a queued block is forwarded: the expected word is returned and the memory read count does not change. The queue is also filled to capacity, and the bench confirms that the next modified miss stalls until writes are released. Once released, the writes must reach memory in displacement order; the bench judges this by final memory contents and by the logged sequence of write tags.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_EVICT = 2'd1,
        S_FILL  = 2'd2,
        S_RESP  = 2'd3
    } cwb_state_e;
endpackage

// File: rtl/cwb_lines.sv
module cwb_lines #(
    parameter int LINES  = 2,
    parameter int TAG_W  = 4,
    parameter int WORD_W = 8,
    parameter int OFF_W  = 1,
    localparam int BLK_W = WORD_W * (1 << OFF_W),
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [BLK_W-1:0] hit_data,
    output logic [IDX_W-1:0] vic_idx,
    input  logic [IDX_W-1:0] sel_idx,
    output logic             sel_valid,
    output logic             sel_dirty,
    output logic [TAG_W-1:0] sel_tag,
    output logic [BLK_W-1:0] sel_data,
    input  logic             acc_en,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [OFF_W-1:0] acc_off,
    input  logic             acc_we,
    input  logic [WORD_W-1:0] acc_wdata,
    input  logic             inval_en,
    input  logic [IDX_W-1:0] inval_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [BLK_W-1:0] fill_data,
    input  logic             fill_dirty
);
    logic [LINES-1:0] valid_q, dirty_q, match;
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [BLK_W-1:0] data_q [LINES];
    logic [IDX_W-1:0] age_q  [LINES];
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;

    for (genvar g = 0; g < LINES; g++) begin : g_match
        assign match[g] = valid_q[g] && (tag_q[g] == look_tag);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
        hit_data = data_q[hit_idx];
    end

    // victim: lowest invalid line, otherwise the oldest one
    always_comb begin
        logic found;
        found   = 1'b0;
        vic_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!valid_q[i] && !found) begin
                vic_idx = IDX_W'(i);
                found   = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < LINES; i++) begin
                if (age_q[i] == IDX_W'(LINES - 1)) vic_idx = IDX_W'(i);
            end
        end
    end

    assign sel_valid = valid_q[sel_idx];
    assign sel_dirty = dirty_q[sel_idx];
    assign sel_tag   = tag_q[sel_idx];
    assign sel_data  = data_q[sel_idx];

    assign touch_en  = acc_en || fill_en;
    assign touch_idx = fill_en ? fill_idx : acc_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i]  <= '0;
                data_q[i] <= '0;
                age_q[i]  <= IDX_W'(i);
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (inval_en && inval_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b0;
                    dirty_q[i] <= 1'b0;
                end
                if (fill_en && fill_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    dirty_q[i] <= fill_dirty;
                    tag_q[i]   <= fill_tag;
                    data_q[i]  <= fill_data;
                end
                if (acc_en && acc_we && acc_idx == IDX_W'(i)) begin
                    data_q[i][int'(acc_off)*WORD_W +: WORD_W] <= acc_wdata;
                    dirty_q[i] <= 1'b1;
                end
                if (touch_en) begin
                    if (touch_idx == IDX_W'(i))
                        age_q[i] <= '0;
                    else if (age_q[i] < age_q[touch_idx])
                        age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    // R7
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R6
    fill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !valid_q[fill_idx]);
endmodule

// File: rtl/cwb_evbuf.sv
module cwb_evbuf #(
    parameter int DEPTH = 2,
    parameter int TAG_W = 4,
    parameter int BLK_W = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic [BLK_W-1:0] push_data,
    input  logic             pop,
    output logic             full,
    output logic             empty,
    output logic [TAG_W-1:0] head_tag,
    output logic [BLK_W-1:0] head_data,
    input  logic [TAG_W-1:0] look_tag,
    output logic             fwd_hit,
    output logic [BLK_W-1:0] fwd_data
);
    logic [TAG_W-1:0] tag_m  [DEPTH];
    logic [BLK_W-1:0] data_m [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (cnt == CNT_W'(DEPTH));
    assign empty     = (cnt == '0);
    assign head_tag  = tag_m[rd_ptr];
    assign head_data = data_m[rd_ptr];

    // scan head to tail, last match is the youngest copy
    always_comb begin
        fwd_hit  = 1'b0;
        fwd_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int p;
            p = int'(rd_ptr) + k;
            if (p >= DEPTH) p = p - DEPTH;
            if (k < int'(cnt) && tag_m[p] == look_tag) begin
                fwd_hit  = 1'b1;
                fwd_data = data_m[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tag_m[i]  <= '0;
                data_m[i] <= '0;
            end
        end else begin
            if (push) begin
                tag_m[wr_ptr]  <= push_tag;
                data_m[wr_ptr] <= push_data;
                wr_ptr         <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/cwb_cache.sv
module cwb_cache #(
    parameter int TAG_W    = 4,
    parameter int OFF_W    = 1,
    parameter int WORD_W   = 8,
    parameter int LINES    = 2,
    parameter int WB_DEPTH = 2,
    parameter int CNT_W    = 16,
    localparam int ADDR_W  = TAG_W + OFF_W,
    localparam int BLK_W   = WORD_W * (1 << OFF_W),
    localparam int IDX_W   = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_rd_req,
    output logic [TAG_W-1:0]  mem_rd_tag,
    input  logic              mem_rd_ack,
    input  logic [BLK_W-1:0]  mem_rd_data,
    output logic              mem_wr_req,
    output logic [TAG_W-1:0]  mem_wr_tag,
    output logic [BLK_W-1:0]  mem_wr_data,
    input  logic              mem_wr_ack,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count,
    output logic [CNT_W-1:0]  dirty_evict_count
);
    import cwb_pkg::*;

    cwb_state_e state_q, state_d;

    logic [TAG_W-1:0]  req_tag;
    logic [OFF_W-1:0]  req_off;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx, vic_idx, vic_q;
    logic [BLK_W-1:0]  hit_data, sel_data, fwd_data, fill_src, fill_blk;
    logic              sel_valid, sel_dirty;
    logic [TAG_W-1:0]  sel_tag;
    logic              acc_en, inval_en, fill_en, push, pop;
    logic              buf_full, buf_empty, fwd_hit;
    logic              hit_inc, miss_inc, dev_inc, latch_vic, cap_en;
    logic [WORD_W-1:0] cap_val, rdata_q;

    assign req_tag = cpu_addr[ADDR_W-1:OFF_W];
    assign req_off = cpu_addr[OFF_W-1:0];

    cwb_lines #(.LINES(LINES), .TAG_W(TAG_W), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .look_tag(req_tag), .hit(hit), .hit_idx(hit_idx), .hit_data(hit_data),
        .vic_idx(vic_idx), .sel_idx(vic_q),
        .sel_valid(sel_valid), .sel_dirty(sel_dirty), .sel_tag(sel_tag), .sel_data(sel_data),
        .acc_en(acc_en), .acc_idx(hit_idx), .acc_off(req_off), .acc_we(cpu_we),
        .acc_wdata(cpu_wdata),
        .inval_en(inval_en), .inval_idx(vic_q),
        .fill_en(fill_en), .fill_idx(vic_q), .fill_tag(req_tag), .fill_data(fill_blk),
        .fill_dirty(cpu_we)
    );

    cwb_evbuf #(.DEPTH(WB_DEPTH), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_evbuf (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_tag(sel_tag), .push_data(sel_data),
        .pop(pop), .full(buf_full), .empty(buf_empty),
        .head_tag(mem_wr_tag), .head_data(mem_wr_data),
        .look_tag(req_tag), .fwd_hit(fwd_hit), .fwd_data(fwd_data)
    );

    // merge a pending store into the block being installed
    always_comb begin
        fill_blk = fill_src;
        if (cpu_we) fill_blk[int'(req_off)*WORD_W +: WORD_W] = cpu_wdata;
    end

    assign mem_rd_tag = req_tag;
    assign mem_wr_req = !buf_empty && (state_q != S_FILL);
    assign pop        = mem_wr_req && mem_wr_ack;
    assign cpu_ready  = (state_q == S_RESP);
    assign cpu_rdata  = rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        acc_en     = 1'b0;
        inval_en   = 1'b0;
        fill_en    = 1'b0;
        push       = 1'b0;
        mem_rd_req = 1'b0;
        fill_src   = '0;
        hit_inc    = 1'b0;
        miss_inc   = 1'b0;
        dev_inc    = 1'b0;
        latch_vic  = 1'b0;
        cap_en     = 1'b0;
        cap_val    = '0;
        unique case (state_q)
            S_IDLE: begin
                if (cpu_valid) begin
                    if (hit) begin
                        acc_en  = 1'b1;
                        hit_inc = 1'b1;
                        cap_en  = 1'b1;
                        cap_val = cpu_we ? cpu_wdata
                                         : hit_data[int'(req_off)*WORD_W +: WORD_W];
                        state_d = S_RESP;
                    end else begin
                        miss_inc  = 1'b1;
                        latch_vic = 1'b1;
                        state_d   = S_EVICT;
                    end
                end
            end
            S_EVICT: begin
                if (sel_valid && sel_dirty) begin
                    if (!buf_full) begin
                        push     = 1'b1;
                        inval_en = 1'b1;
                        dev_inc  = 1'b1;
                        state_d  = S_FILL;
                    end
                end else begin
                    inval_en = sel_valid;
                    state_d  = S_FILL;
                end
            end
            S_FILL: begin
                if (fwd_hit) begin
                    fill_en  = 1'b1;
                    fill_src = fwd_data;
                end else begin
                    mem_rd_req = 1'b1;
                    if (mem_rd_ack) begin
                        fill_en  = 1'b1;
                        fill_src = mem_rd_data;
                    end
                end
                if (fill_en) begin
                    cap_en  = 1'b1;
                    cap_val = fill_blk[int'(req_off)*WORD_W +: WORD_W];
                    state_d = S_RESP;
                end
            end
            S_RESP: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vic_q             <= '0;
            rdata_q           <= '0;
            hit_count         <= '0;
            miss_count        <= '0;
            dirty_evict_count <= '0;
        end else begin
            if (latch_vic) vic_q   <= vic_idx;
            if (cap_en)    rdata_q <= cap_val;
            if (hit_inc)   hit_count  <= hit_count + 1'b1;
            if (miss_inc)  miss_count <= miss_count + 1'b1;
            if (dev_inc)   dirty_evict_count <= dirty_evict_count + 1'b1;
        end
    end

    // R3
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> mem_rd_req);
endmodule

// File: tb/tb_cwb_cache.sv
`timescale 1ns/1ps
module tb_cwb_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [4:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic        mem_rd_req, mem_wr_req;
    logic [3:0]  mem_rd_tag, mem_wr_tag;
    logic        mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic [15:0] mem_wr_data;
    logic [15:0] hit_count, miss_count, dirty_evict_count;

    always #2.5 clk = ~clk;

    cwb_cache dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_rd_req(mem_rd_req), .mem_rd_tag(mem_rd_tag), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_tag(mem_wr_tag), .mem_wr_data(mem_wr_data),
        .mem_wr_ack(mem_wr_ack),
        .hit_count(hit_count), .miss_count(miss_count),
        .dirty_evict_count(dirty_evict_count)
    );

    int checks = 0, failures = 0;
    logic [7:0] mem [32];
    logic [7:0] shadow [32];
    int rd_count = 0, wr_count = 0, rd_wait = 0, wr_wait = 0, prio_viol = 0;
    int wr_log [16];
    bit hold_wr = 1'b0;
    int exp_hits = 0, exp_miss = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // memory model: acknowledges after two cycles of request
    always @(negedge clk) begin
        if (mem_rd_req && mem_wr_req) prio_viol++;
        if (mem_rd_ack) mem_rd_ack = 1'b0;
        else if (mem_rd_req) begin
            rd_wait++;
            if (rd_wait >= 2) begin
                mem_rd_data = {mem[{mem_rd_tag, 1'b1}], mem[{mem_rd_tag, 1'b0}]};
                mem_rd_ack  = 1'b1;
                rd_count++;
                rd_wait = 0;
            end
        end else rd_wait = 0;
        if (mem_wr_ack) mem_wr_ack = 1'b0;
        else if (mem_wr_req && !hold_wr) begin
            wr_wait++;
            if (wr_wait >= 2) begin
                mem[{mem_wr_tag, 1'b0}] = mem_wr_data[7:0];
                mem[{mem_wr_tag, 1'b1}] = mem_wr_data[15:8];
                if (wr_count < 16) wr_log[wr_count] = int'(mem_wr_tag);
                wr_count++;
                mem_wr_ack = 1'b1;
                wr_wait = 0;
            end
        end else wr_wait = 0;
    end

    task automatic start(input bit we, input int addr, input int wd);
        @(negedge clk); #1;
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = 5'(addr); cpu_wdata = 8'(wd);
        if (we) shadow[addr] = 8'(wd);
    endtask

    task automatic finish_acc(input int addr, input bit exp_hit, input string req, output int cyc);
        cyc = 0;
        do begin
            @(negedge clk); #1; cyc++;
        end while (!cpu_ready && cyc < 400);
        chk(req, "ready seen", int'(cpu_ready), 1);
        chk(req, "rdata", int'(cpu_rdata), int'(shadow[addr]));
        cpu_valid = 1'b0;
        if (exp_hit) exp_hits++; else exp_miss++;
        chk(req, "hit_count", int'(hit_count), exp_hits);
        chk(req, "miss_count", int'(miss_count), exp_miss);
    endtask

    task automatic access(input bit we, input int addr, input int wd, input bit exp_hit,
                          input string req);
        int cyc, rc0;
        rc0 = rd_count;
        start(we, addr, wd);
        finish_acc(addr, exp_hit, req, cyc);
        if (exp_hit) begin
            chk("R3", "hit latency", cyc, 1);
            chk("R3", "no read on hit", rd_count, rc0);
        end
    endtask

    task automatic wait_writes(input int n);
        for (int i = 0; i < 200 && wr_count < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic t_reset;
        chk("R1", "ready", int'(cpu_ready), 0);
        chk("R1", "rd_req", int'(mem_rd_req), 0);
        chk("R1", "wr_req", int'(mem_wr_req), 0);
        chk("R1", "counters", int'(hit_count) + int'(miss_count) + int'(dirty_evict_count), 0);
    endtask

    task automatic t_alloc_and_hits;
        access(0, 1, 0, 0, "R2");
        chk("R2", "block reads", rd_count, 1);
        access(0, 0, 0, 1, "R3");
        access(1, 0, 8'hAA, 1, "R4");
        repeat (6) @(negedge clk);
        #1 chk("R4", "no write on store hit", wr_count, 0);
    endtask

    task automatic t_evictions;
        access(0, 7, 0, 0, "R7");
        access(0, 2, 0, 0, "R6");
        wait_writes(1);
        chk("R6", "writes", wr_count, 1);
        chk("R6", "tag written", wr_log[0], 0);
        chk("R6", "word0 in memory", int'(mem[0]), 8'hAA);
        chk("R6", "word1 in memory", int'(mem[1]), int'(shadow[1]));
        chk("R6", "dirty_evict_count", int'(dirty_evict_count), 1);
        access(0, 6, 0, 1, "R7");
        access(0, 8, 0, 0, "R5");
        repeat (8) @(negedge clk);
        #1 chk("R5", "clean victim no write", wr_count, 1);
        access(0, 7, 0, 1, "R7");
    endtask

    task automatic t_queue;
        int rc0, cyc;
        bit seen;
        hold_wr = 1'b1;
        access(1, 8, 8'h55, 1, "R4");
        access(0, 10, 0, 0, "R7");
        access(0, 12, 0, 0, "R11");
        rc0 = rd_count;
        access(0, 8, 0, 0, "R10");
        chk("R10", "no memory read on forward", rd_count, rc0);
        chk("R10", "memory still stale", int'(mem[8]), 8'h55 == mem[8] ? 0 : int'(mem[8]));
        access(1, 9, 8'h66, 1, "R4");
        access(1, 12, 8'h77, 1, "R4");
        access(0, 14, 0, 0, "R6");
        chk("R6", "dirty_evict_count", int'(dirty_evict_count), 3);
        start(0, 16, 0);
        seen = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #1;
            if (cpu_ready) seen = 1'b1;
        end
        chk("R9", "stalled while queue full", int'(seen), 0);
        chk("R9", "no write yet", wr_count, 1);
        hold_wr = 1'b0;
        finish_acc(16, 0, "R9", cyc);
        chk("R9", "dirty_evict_count", int'(dirty_evict_count), 4);
        wait_writes(4);
        chk("R8", "write count", wr_count, 4);
        chk("R8", "first tag", wr_log[1], 4);
        chk("R8", "second tag", wr_log[2], 4);
        chk("R8", "third tag", wr_log[3], 6);
        chk("R8", "mem[8]", int'(mem[8]), 8'h55);
        chk("R8", "mem[9] newest", int'(mem[9]), 8'h66);
        chk("R8", "mem[12]", int'(mem[12]), 8'h77);
        access(0, 9, 0, 0, "R2");
        chk("R11", "no write during refill", prio_viol, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            mem[i]    = 8'((i * 37 + 11) & 8'hFF);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        @(negedge clk); #1 t_reset();
        t_alloc_and_hits();
        t_evictions();
        t_queue();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule